// File: doc/BRIEF.md
# Opcode Prefetch Buffer with Injection

This block fetches instruction bytes ahead of the control sequencer. It requests data from the memory sequencer at a running fetch address. It accepts chunks of one, two or four bytes per cycle and appends them to a circular byte queue. When the bytes at the head of the queue form a complete opcode, the block offers that opcode, byte-ordered and length-tagged, and holds it until the sequencer takes it. Fetching continues while an opcode waits, so a queue that already holds the next opcode can issue it in the very next cycle without any memory access.

Interrupts and aborts do not use a separate control path. At an opcode boundary, a pending abort or interrupt flushes the queue and moves the fetch address to a redirect address supplied with the request. It then places a one-byte synthetic handler opcode in the offer slot, which the sequencer consumes like any other opcode.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, no opcode is offered, a fetch is requested, and the fetch address equals RESET_ADDR.
- R2: An accepted chunk (mem_req and mem_ack) carries 1, 2 or 4 bytes for mem_width 0, 1 or 2 (3 is illegal). Lane i (bits 8i+7:8i) holds the byte at fetch address + i. The bytes are appended in lane order, and the fetch address advances by the chunk size.
- R3: A fetch is requested exactly when at least 4 of the DEPTH queue bytes are free, so the queue never overflows.
- R4: The opcode length is bits[1:0] of the first byte plus one. When the first byte equals PREFIX (default 0xFF), the length is 2 plus bits[1:0] of the second byte.
- R5: op_valid is high exactly when a complete opcode sits at the queue head or a synthetic opcode is pending. op_data byte k (bits 8k+7:8k) is opcode byte k, and bytes at or beyond op_len are zero. An offered opcode stays unchanged until it is taken.
- R6: Taking a normal opcode removes exactly op_len bytes. An opcode already complete behind it is offered in the next cycle.
- R7: An interrupt at a boundary (op_valid low, or op_valid and op_take) flushes the queue and moves the fetch address to irq_addr. In the next cycle it offers op_kind 1, op_len 1, with op_data byte 0 equal to IRQ_CODE.
- R8: An abort at a boundary does the same with abort_addr, op_kind 2 and ABORT_CODE, and it wins over a simultaneous interrupt.
- R9: A request arriving while an offered opcode is not being taken has no effect in that cycle.
- R10: op_take while op_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Fetch request to the memory sequencer |
| mem_addr | output | ADDR_W | Current fetch address |
| mem_ack | input | 1 | Chunk delivered this cycle |
| mem_width | input | 2 | Chunk size code: 0=1, 1=2, 2=4 bytes |
| mem_data | input | 32 | Chunk bytes, lowest address in lane 0 |
| op_valid | output | 1 | Opcode offered |
| op_len | output | 3 | Offered opcode length in bytes (1..5) |
| op_kind | output | 2 | 0 normal, 1 interrupt, 2 abort |
| op_data | output | 40 | Offered opcode bytes, zero-filled past op_len |
| op_take | input | 1 | Sequencer takes the offered opcode |
| irq_req | input | 1 | Interrupt pending |
| irq_addr | input | ADDR_W | Fetch address after an interrupt injection |
| abort_req | input | 1 | Abort signalled by the sequencer |
| abort_addr | input | ADDR_W | Fetch address after an abort injection |

## Verification
The bench builds the block with DEPTH 16 and ADDR_W 16. The queue threshold is then 12 bytes, so a short run of four-byte chunks with no takes reaches the point where requests stop. The 16-bit address space makes the prefix byte 0xFF and every length code appear often in the computed memory image. Head pointer wraparound, five-byte prefixed opcodes that straddle the wrap, and redirects to random addresses all occur within a few thousand cycles.

// File: rtl/opfetch_unit.sv
`timescale 1ns/1ps
module opfetch_unit #(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter logic [7:0] PREFIX = 8'hFF,
  parameter logic [7:0] IRQ_CODE = 8'hF0,
  parameter logic [7:0] ABORT_CODE = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [1:0]        mem_width,
  input  logic [31:0]       mem_data,
  output logic              op_valid,
  output logic [2:0]        op_len,
  output logic [1:0]        op_kind,
  output logic [39:0]       op_data,
  input  logic              op_take,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_addr,
  input  logic              abort_req,
  input  logic [ADDR_W-1:0] abort_addr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int LOW_MARK = DEPTH - 4;

  logic [7:0]       fifo [DEPTH];
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [1:0]       inj;

  logic [7:0] b0;
  logic [1:0] b1_lo;
  logic       is_pfx, full_op, take_ok, boundary, redirect, push, pop;
  logic [2:0] need, nbytes;
  logic [7:0] code;

  assign b0     = fifo[head];
  assign b1_lo  = fifo[PTR_W'(head + PTR_W'(1))][1:0];
  assign is_pfx = (b0 == PREFIX);
  assign need   = is_pfx ? 3'(b1_lo) + 3'd2 : 3'(b0[1:0]) + 3'd1;
  assign full_op = is_pfx ? (count >= CNT_W'(2) && count >= CNT_W'(need))
                          : (count != '0 && count >= CNT_W'(need));
  assign nbytes = (mem_width == 2'd0) ? 3'd1 : (mem_width == 2'd1) ? 3'd2 : 3'd4;

  assign mem_req  = (count <= CNT_W'(LOW_MARK));
  assign op_valid = (inj != 2'd0) || full_op;
  assign op_len   = (inj != 2'd0) ? 3'd1 : need;
  assign op_kind  = inj;
  assign code     = (inj == 2'd2) ? ABORT_CODE : IRQ_CODE;

  assign take_ok  = op_valid && op_take;
  assign boundary = !op_valid || op_take;
  assign redirect = boundary && (irq_req || abort_req);
  assign push     = mem_req && mem_ack;
  assign pop      = take_ok && (inj == 2'd0);

  for (genvar k = 0; k < 5; k++) begin : g_lane
    assign op_data[8*k +: 8] = (inj != 2'd0) ? ((k == 0) ? code : 8'h00)
                             : ((need > 3'(k)) ? fifo[PTR_W'(head + PTR_W'(k))] : 8'h00);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < 4; i++) begin
        if (3'(i) < nbytes)
          fifo[PTR_W'(int'(head) + int'(count) + i)] <= mem_data[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      count    <= '0;
      inj      <= 2'd0;
      mem_addr <= RESET_ADDR;
    end else if (redirect) begin
      head     <= '0;
      count    <= '0;
      inj      <= abort_req ? 2'd2 : 2'd1;
      mem_addr <= abort_req ? abort_addr : irq_addr;
    end else begin
      head  <= head + (pop ? PTR_W'(need) : PTR_W'(0));
      count <= count + (push ? CNT_W'(nbytes) : CNT_W'(0)) - (pop ? CNT_W'(need) : CNT_W'(0));
      if (push) mem_addr <= mem_addr + ADDR_W'(nbytes);
      if (take_ok && inj != 2'd0) inj <= 2'd0;
    end
  end

  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (CNT_W'(DEPTH) - count) >= CNT_W'(4));
  p_width_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |-> mem_width != 2'b11);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !redirect) |=> mem_addr == $past(mem_addr) + ADDR_W'($past(nbytes)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_take) |=> op_valid && $stable(op_data) && $stable(op_len) && $stable(op_kind));
  p_abort_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && abort_req) |=> op_kind == 2'd2 && op_valid && mem_addr == $past(abort_addr));
  p_irq_inject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && irq_req && !abort_req) |=> op_kind == 2'd1 && op_len == 3'd1 && mem_addr == $past(irq_addr));
endmodule

// File: tb/test_opfetch_unit.sv
`timescale 1ns/1ps
module test_opfetch_unit;
  localparam int ADDR_W = 16;
  localparam logic [15:0] RST_A = 16'h0000;

  logic clk = 0, rst_n = 0;
  logic mem_req, mem_ack = 0;
  logic [15:0] mem_addr, irq_addr = 0, abort_addr = 0;
  logic [1:0] mem_width = 0, op_kind;
  logic [31:0] mem_data = 0;
  logic op_valid, op_take = 0, irq_req = 0, abort_req = 0;
  logic [2:0] op_len;
  logic [39:0] op_data;

  opfetch_unit #(.DEPTH(16), .ADDR_W(ADDR_W)) i_opfetch_unit (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_width(mem_width), .mem_data(mem_data),
    .op_valid(op_valid), .op_len(op_len), .op_kind(op_kind), .op_data(op_data),
    .op_take(op_take), .irq_req(irq_req), .irq_addr(irq_addr),
    .abort_req(abort_req), .abort_addr(abort_addr));

  always #2.5 clk = ~clk;

  int checks = 0, bad = 0;
  logic [7:0] mq [16];
  int mcnt = 0, mkind = 0;
  logic [15:0] maddr = RST_A;
  string ctx = "R5";

  function automatic logic [7:0] membyte(input logic [15:0] a);
    logic [15:0] h = a * 16'd40503;
    return h[15:8] ^ a[7:0];
  endfunction

  function automatic int need_len();
    int n;
    if (mcnt == 0) return 0;
    if (mq[0] == 8'hFF) begin
      if (mcnt < 2) return 0;
      n = 2 + int'(mq[1][1:0]);
    end else n = 1 + int'(mq[0][1:0]);
    return (mcnt >= n) ? n : 0;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n = need_len();
    bit v = (mkind != 0) || (n != 0);
    logic [39:0] ed = '0;
    chk("R3 mem_req", 64'(mem_req), 64'(mcnt <= 12));
    chk("R2 mem_addr", 64'(mem_addr), 64'(maddr));
    chk({ctx, " op_valid"}, 64'(op_valid), 64'(v));
    if (v) begin
      if (mkind != 0) begin
        ed[7:0] = (mkind == 2) ? 8'hF8 : 8'hF0;
        chk("R4 op_len", 64'(op_len), 64'd1);
      end else begin
        for (int k = 0; k < n; k++) ed[8*k +: 8] = mq[k];
        chk("R4 op_len", 64'(op_len), 64'(n));
      end
      chk({ctx, " op_kind"}, 64'(op_kind), 64'(mkind));
      chk({ctx, " op_data"}, 64'(op_data), 64'(ed));
    end
  endtask

  task automatic step(input bit ack, input logic [1:0] w, input bit take,
                      input bit irq, input bit abt, input logic [15:0] ia, input logic [15:0] aa);
    int n = need_len();
    bit v = (mkind != 0) || (n != 0);
    bit req = (mcnt <= 12);
    int nb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    compare();
    mem_ack = ack; mem_width = w; op_take = take;
    irq_req = irq; abort_req = abt; irq_addr = ia; abort_addr = aa;
    mem_data = $urandom;
    for (int i = 0; i < nb; i++) mem_data[8*i +: 8] = membyte(maddr + 16'(i));
    ctx = "R5";
    if ((!v || take) && (irq || abt)) begin
      mcnt = 0; maddr = abt ? aa : ia; mkind = abt ? 2 : 1;
      ctx = abt ? "R8" : "R7";
    end else begin
      if (v && take && mkind == 0) begin
        for (int i = 0; i < 16 - n; i++) mq[i] = mq[i + n];
        mcnt -= n; ctx = "R6";
      end else if (v && take) mkind = 0;
      if (req && ack) begin
        for (int i = 0; i < nb; i++) mq[mcnt + i] = membyte(maddr + 16'(i));
        mcnt += nb; maddr += 16'(nb);
      end
      if (!v && take) ctx = "R10";
      if (v && !take && (irq || abt)) ctx = "R9";
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 op_valid", 64'(op_valid), 64'd0);
    chk("R1 mem_req", 64'(mem_req), 64'd1);
    chk("R1 mem_addr", 64'(mem_addr), 64'(RST_A));
    // R3 fill without takes until requests stop
    for (int c = 0; c < 8; c++) step(1, 2'd2, 0, 0, 0, 0, 0);
    chk("R3 stopped", 64'(mem_req), 64'd0);
    // R10 take with nothing offered after a redirect
    step(0, 0, 1, 1, 0, 16'h1200, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 2'd0, 1, 0, 0, 0, 0);
    // R8 abort wins over interrupt
    step(1, 2'd1, 1, 1, 1, 16'h2200, 16'h3300);
    // R9 request while injected opcode is held
    step(1, 2'd2, 0, 1, 0, 16'h4400, 0);
    step(1, 2'd2, 1, 0, 0, 0, 0);
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 9) < 7, 2'($urandom_range(0, 2)), $urandom_range(0, 1) == 1,
           r < 3, r >= 97, 16'($urandom), 16'($urandom));
    end
    for (int c = 0; c < 200; c++) step(1, 2'($urandom_range(0, 2)), 1, 0, 0, 0, 0);
    compare();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule